// File: doc/BRIEF.md
# Unique-Word Triggered Packet Gate

This block sits at the front of a serial receiver. It samples one bit per clock and keeps the most recent bits in a search register. It waits for a configured 16-bit sync pattern to appear there. When the register holds the pattern, a gate opens for a counted number of cycles. While the gate is open, each incoming bit is copied to a registered serial output. When the count runs out, the gate closes and the search starts again from an empty register.

The sync pattern and the packet length are parameters. The defaults are 0xF0F0 and 1064. A status output shows when the gate is open. A one-cycle marker flags the last open cycle, so downstream logic can frame the packet without its own counter.

Top module: `uw_packet_gate`

## Requirements
- R1: While `rst_n` is low at a rising edge, the search register, counter, gate and data output all clear. After that edge, `ser_out`, `gate_open` and `pkt_last` read 0.
- R2: Bits enter the search register at bit 0, and older bits move toward bit 15. The comparison uses all 16 bits. If the last 16 bits sampled, oldest first, equal `UNIQUE_WORD` (the oldest bit matches its MSB), then `gate_open` rises exactly one clock later. The bit sampled on that intervening edge is not forwarded.
- R3: Once open, the gate stays open for exactly PKT_LEN+1 consecutive cycles. The bit sampled on each of those edges appears on `ser_out` after that edge.
- R4: While the gate is open, the search register is held at zero. A copy of the sync word inside the payload never opens a further packet. After the gate closes, detection starts again from an all-zero register.
- R5: The internal count increases by one on each open cycle and returns to zero on every closed cycle. Its width holds PKT_LEN+1 without wrapping.
- R6: While the gate is closed, `ser_out` keeps its last value whatever `ser_in` does.
- R7: `pkt_last` is high in exactly the final open cycle of each packet and low at all other times. The gate is closed on the next cycle unless a new word has been detected.
- R8: A 16-bit sequence that differs from `UNIQUE_WORD` in any single bit does not open the gate.
- R9: A sync word sent right after a packet ends is detected. Its gate opens one cycle after the word completes, with no extra dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Incoming serial bit |
| ser_out | output | 1 | Registered forwarded bit; holds its value while the gate is closed |
| gate_open | output | 1 | High while a packet is being forwarded |
| pkt_last | output | 1 | High in the final forwarding cycle of a packet |

## Verification
The assertions take these for granted:
- `ser_in` is a clean, defined bit at every rising edge.
- Reset is held low for at least one edge before checking begins.
- The sync word is not all zeros, since a zero word would match the cleared register right after every packet.

The stimulus keeps to these limits. It changes `ser_in` only on the falling edge and holds reset across several edges. It draws random bits from a seeded generator, and sometimes inserts the sync word whole, so that packets open often and also open at the earliest allowed cycle.

// File: rtl/uwg_pkg.sv
// Package: shared widths and helpers for the unique-word packet gate.
// Assumes: the counter width is derived from the packet length by the caller.
package uwg_pkg;
    localparam int UW_W = 16;
    typedef logic [UW_W-1:0] uword_t;

    // Width needed to hold values 0..max_val inclusive.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/uwg_search.sv
// Module: uwg_search
// Keeps the last UW_W sampled bits and flags when they equal the sync word.
// Assumes: gate_open comes from the window counter; the register is
// held at zero while a packet is forwarded.
module uwg_search
    import uwg_pkg::*;
#(
    parameter uword_t SYNC = 16'hF0F0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic gate_open,
    output logic match
);
    uword_t window_q;

    // Shift register: cleared on reset or while the gate is open, else shifts at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            window_q <= '0;
        else if (gate_open)
            window_q <= '0;
        else
            window_q <= {window_q[UW_W-2:0], bit_in};
    end

    // Full-width comparison against the configured word.
    assign match = (window_q == SYNC);

    // R4: an open cycle leaves the search register empty.
    a_r4_cleared_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |=> (window_q == '0));

    // R2: a closed cycle shifts the sampled bit into bit 0.
    a_r2_shift_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> (window_q[0] == $past(bit_in)));
endmodule

// File: rtl/uwg_window.sv
// Module: uwg_window
// Opens the gate on a match and counts forwarded cycles until the length is reached.
// Assumes: PKT_LEN >= 1; CNT_W is wide enough for PKT_LEN+1.
module uwg_window #(
    parameter int PKT_LEN = 1064,
    parameter int CNT_W   = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    output logic gate_open,
    output logic fwd_en,
    output logic last
);
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(PKT_LEN);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;

    // Gate flag: set on match or held, until the count reaches the length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else
            open_q <= (match || open_q) && (cnt_q < LEN_C);
    end

    // Cycle counter: increments while open, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (open_q)
            cnt_q <= cnt_q + ONE_C;
        else
            cnt_q <= '0;
    end

    assign gate_open = open_q;
    assign fwd_en    = open_q && (cnt_q <= LEN_C);
    assign last      = open_q && (cnt_q >= LEN_C);

    // R5: the count never passes the length while open.
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (cnt_q <= LEN_C));

    // R5: a closed cycle leaves the count at zero.
    a_r5_cnt_zero_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |=> (cnt_q == '0));

    // R3: the gate stays open until its last cycle.
    a_r3_open_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !last) |=> open_q);

    // R7: the last cycle closes the gate.
    a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !open_q);
endmodule

// File: rtl/uwg_outreg.sv
// Module: uwg_outreg
// Registers the forwarded bit and holds it when forwarding is disabled.
// Assumes: fwd_en is only high during open gate cycles.
module uwg_outreg (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic fwd_en,
    output logic bit_out
);
    logic out_q;

    // Output flop: loads the input when forwarding, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else if (fwd_en)
            out_q <= bit_in;
    end

    assign bit_out = out_q;

    // R6: no forwarding means the output is unchanged.
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |=> $stable(out_q));

    // R3: forwarding copies the sampled bit.
    a_r3_forward_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en |=> (out_q == $past(bit_in)));
endmodule

// File: rtl/uw_packet_gate.sv
// Module: uw_packet_gate (top)
// Serial front end: searches for a 16-bit sync word, then forwards a counted
// packet of PKT_LEN+1 bits to a registered output and returns to search.
// Assumes: one valid bit per clock on ser_in; UNIQUE_WORD is non-zero.
module uw_packet_gate
    import uwg_pkg::*;
#(
    parameter uword_t UNIQUE_WORD = 16'hF0F0,
    parameter int     PKT_LEN     = 1064
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic ser_out,
    output logic gate_open,
    output logic pkt_last
);
    localparam int CNT_W = cnt_width(PKT_LEN + 1);

    logic match;
    logic open_w;
    logic fwd_w;
    logic last_w;

    uwg_search #(.SYNC(UNIQUE_WORD)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (ser_in),
        .gate_open (open_w),
        .match     (match)
    );

    uwg_window #(.PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .gate_open (open_w),
        .fwd_en    (fwd_w),
        .last      (last_w)
    );

    uwg_outreg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (ser_in),
        .fwd_en  (fwd_w),
        .bit_out (ser_out)
    );

    assign gate_open = open_w;
    assign pkt_last  = last_w;

    // R2: a match seen with the gate closed opens it on the next cycle.
    a_r2_open_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !open_w) |=> open_w);

    // R7: the last-cycle marker only appears while the gate is open.
    a_r7_last_inside_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |-> gate_open);
endmodule

// File: tb/uw_packet_gate_tb.sv
module uw_packet_gate_tb;
    localparam logic [15:0] UW  = 16'hF0F0;
    localparam int          LEN = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out, gate_open, pkt_last;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int open_run = 0;
    bit saw_open = 1'b0;

    // Reference state, derived from the requirements.
    logic [15:0] m_hist;
    logic        m_open;
    int          m_left;
    logic        m_dout;

    always #4 clk = ~clk;

    uw_packet_gate #(.UNIQUE_WORD(UW), .PKT_LEN(LEN)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .gate_open (gate_open),
        .pkt_last  (pkt_last)
    );

    // Reference: the gate opens the cycle after the history equals the word,
    // then forwards LEN+1 bits, counting down what remains.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist <= '0; m_open <= 1'b0; m_left <= 0; m_dout <= 1'b0;
        end else if (m_open) begin
            m_dout <= ser_in;
            m_hist <= '0;
            if (m_left == 0) m_open <= 1'b0;
            else m_left <= m_left - 1;
        end else begin
            m_hist <= {m_hist[14:0], ser_in};
            if (m_hist == UW) begin
                m_open <= 1'b1;
                m_left <= LEN;
            end
        end
    end

    function automatic logic word_bit(input logic [15:0] w, input int idx);
        return w[15 - idx];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the reference (called at the falling edge).
    task automatic compare_all();
        check("R2 gate_open", int'(gate_open), int'(m_open));
        check("R7 pkt_last", int'(pkt_last), int'(m_open && m_left == 0));
        if (gate_open) check("R3 ser_out", int'(ser_out), int'(m_dout));
        else           check("R6 ser_out", int'(ser_out), int'(m_dout));
        if (gate_open) begin
            open_run++;
            saw_open = 1'b1;
        end
        if (pkt_last) begin
            check("R3 packet length", open_run, LEN + 1);
            open_run = 0;
        end
    endtask

    // Drive one bit, let one rising edge pass, then compare at the falling edge.
    task automatic send_bit(input logic b);
        ser_in = b;
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) open_run = 0;
        else compare_all();
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 0; i < 16; i++) send_bit(word_bit(w, i));
    endtask

    initial begin
        logic [LEN:0] payload;
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset clears everything
        rst_n = 1'b0;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        check("R1 ser_out in reset", int'(ser_out), 0);
        check("R1 gate_open in reset", int'(gate_open), 0);
        check("R1 pkt_last in reset", int'(pkt_last), 0);
        rst_n = 1'b1;

        // R8: one-bit-off words never open the gate
        saw_open = 1'b0;
        for (int k = 0; k < 16; k += 5) begin
            for (int z = 0; z < 16; z++) send_bit(1'b0);
            send_word(UW ^ (16'h1 << k));
            send_bit(1'b0);
        end
        check("R8 near-miss no open", int'(saw_open), 0);

        // R2: exact word, then one discarded bit, then the gate is open
        send_word(UW);
        check("R2 closed right after word", int'(gate_open), 0);
        send_bit(1'b1);
        check("R2 open one cycle later", int'(gate_open), 1);

        // R3/R4: payload containing the sync word
        payload = '0;
        for (int i = 0; i <= LEN; i++) payload[i] = 1'($urandom);
        for (int i = 0; i < 16; i++) payload[2 + i] = word_bit(UW, i);
        for (int i = 0; i < LEN; i++) send_bit(payload[i]);
        check("R7 last cycle flagged", int'(pkt_last), 1);
        send_bit(payload[LEN]);
        check("R3 gate closed after LEN+1", int'(gate_open), 0);
        check("R3 final bit forwarded", int'(ser_out), int'(payload[LEN]));
        saw_open = 1'b0;
        for (int z = 0; z < 16; z++) send_bit(1'b1);
        check("R4 embedded word ignored", int'(saw_open), 0);
        check("R6 output held while closed", int'(ser_out), int'(payload[LEN]));

        // R9: back-to-back packets
        send_word(UW); send_bit(1'b0);
        for (int i = 0; i <= LEN; i++) send_bit(1'($urandom));
        check("R9 first packet closed", int'(gate_open), 0);
        send_word(UW); send_bit(1'b0);
        check("R9 immediate reopen", int'(gate_open), 1);
        for (int i = 0; i <= LEN; i++) send_bit(1'($urandom));

        // R1: reset in the middle of a packet
        send_word(UW); send_bit(1'b1);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        rst_n = 1'b0;
        send_bit(1'b1);
        check("R1 mid-packet gate cleared", int'(gate_open), 0);
        check("R1 mid-packet output cleared", int'(ser_out), 0);
        rst_n = 1'b1;

        // Random traffic with occasional word insertion (R2..R7)
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 40) == 0) send_word(UW);
            else send_bit(1'($urandom));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule